// File: doc/BRIEF.md
# Isochronous IN Endpoint Transmit Buffer

This block holds outgoing data for one isochronous IN endpoint of a full-speed USB device controller. Software loads packets one byte at a time into a pair of packet buffers that are filled and drained in alternation. A buffer becomes a packet, or is "triggered", once it holds the full packet size. Software can also close it early with a short-packet command.

On the bus side, a simplified packet engine reports each IN token. The block answers one cycle later with a data response, carrying the packet length, or with a NAK. The engine then pulls the packet out byte by byte and signals the end of transmission.

A byte-wide control/status register gathers the state software needs. It holds a service flag, a packet-complete flag, a flush command, an underrun flag and the short-packet command. An interrupt line combines the packet-complete flag, gated by a transmit interrupt enable, with the underrun flag. Bus events for a configuration change or an interface change empty both buffers, in the same way as the flush command.

Top module: `isoInTxBuf`

## Requirements
- R1: A buffer is triggered when PKT_BYTES bytes have been written into it, or when a register write sets bit 5 (short-packet command). The short-packet command triggers the current write buffer with whatever length it holds, zero included. Bit 5 is self-clearing and reads 0.
- R2: Register bit 0 (service) reads 1 while at most one buffer is triggered, and 0 while both are triggered.
- R3: An IN token received while no packet is in flight produces a one-cycle response in the next cycle. If the oldest buffer is triggered, the response is `sendOut` with `sendLen` equal to that buffer's byte count. A `byteReq` gets `byteValid` in the next cycle, with the buffer's bytes in the order they were written.
- R4: `txDone` during an in-flight packet frees that buffer and sets register bit 1 (packet complete). Writing 1 to bit 1 clears the flag.
- R5: `irq` is high exactly when (bit 1 and `txIntEn`) or bit 3 is set.
- R6: A set packet-complete flag does not stop a triggered buffer from being sent in answer to a token.
- R7: A token gets `nakOut` when bit 1 is set and no buffer is triggered.
- R8: A token with no buffer triggered and bit 1 clear is answered with `sendOut` and `sendLen` 0, and sets bit 3 (underrun). A `byteReq` after the in-flight packet's bytes are used up returns `byteData` 0 and also sets bit 3. Writing 1 to bit 3 clears the flag.
- R9: Writing 1 to bit 2, or a pulse on `flushCfg` or `flushIntf`, empties both buffers and restarts both at buffer 0. Bits 1 and 3 are left unchanged. Bit 2 always reads 0.
- R10: Bits 4, 6 and 7 always read 0.
- R11: A byte write is ignored while the current write buffer is already triggered, which happens when both buffers hold packets. The packets already loaded keep their length and contents.
- R12: Packets are sent in the order they were triggered, alternating between the two buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | CPU byte write strobe |
| wrData | input | 8 | CPU byte to load |
| regWr | input | 1 | Control/status register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read value |
| txIntEn | input | 1 | Transmit interrupt enable |
| irq | output | 1 | Endpoint interrupt request |
| inToken | input | 1 | IN token pulse from packet engine |
| sendOut | output | 1 | Data response pulse |
| nakOut | output | 1 | NAK response pulse |
| sendLen | output | CNT_W | Length of the data response in bytes |
| byteReq | input | 1 | Packet engine byte pull |
| byteValid | output | 1 | Pulled byte is present |
| byteData | output | 8 | Pulled byte |
| txDone | input | 1 | Packet engine finished the in-flight packet |
| flushCfg | input | 1 | Configuration-change flush event |
| flushIntf | input | 1 | Interface-change flush event |

## Verification
Register flags, the service bit and `irq` change at the clock edge that captures the write, token, pull or done. They are visible in `regRdata` at the falling edge that follows. `sendOut`, `nakOut` and `sendLen` appear one cycle after the token, and `byteValid`/`byteData` one cycle after each `byteReq`. The bench drives each stimulus at a falling edge, waits one full cycle, and compares at the next falling edge, where every one of these results is due. A bench model of both buffers, the fill order and the flags supplies each expected value.

// File: rtl/isoTxPkg.sv
package isoTxPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic wrBuf;
    logic rdEn;
    logic rdBuf;
  } txStrb_t;
endpackage

// File: rtl/isoTxData.sv
module isoTxData
  import isoTxPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PKT_BYTES = 256,
  localparam int AW       = $clog2(PKT_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrb_t           strb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] bankQ [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] store [PKT_BYTES];
    always_ff @(posedge clk) begin
      if (strb.wrEn && strb.wrBuf == 1'(b)) store[wrAddr] <= wrData;
    end
    assign bankQ[b] = store[rdAddr];
  end

  // a pull with no byte left returns zero
  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= strb.rdEn ? bankQ[strb.rdBuf] : '0;
  end
endmodule

// File: rtl/isoTxCtrl.sv
module isoTxCtrl
  import isoTxPkg::*;
#(
  parameter int PKT_BYTES = 256,
  localparam int AW       = $clog2(PKT_BYTES),
  localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             regWr,
  input  logic [7:0]       regWdata,
  input  logic             inToken,
  input  logic             byteReq,
  input  logic             txDone,
  input  logic             flushCfg,
  input  logic             flushIntf,
  output txStrb_t          strb,
  output logic [AW-1:0]    wrAddr,
  output logic [AW-1:0]    rdAddr,
  output logic             sendOut,
  output logic             nakOut,
  output logic [CNT_W-1:0] sendLen,
  output logic             byteValid,
  output logic             pktDone,
  output logic             underrun,
  output logic             svc
);
  localparam int B_DONE  = 1;
  localparam int B_FLUSH = 2;
  localparam int B_UR    = 3;
  localparam int B_SHORT = 5;

  logic [CNT_W-1:0] fill [2];
  logic [1:0]       trig;
  logic             wrSel, rdSel, busy;
  logic [CNT_W-1:0] rdPtr;

  logic flushNow, shortNow, wrAccept, trigNow;
  logic tokGo, byteGo, doneGo, hasByte, urSet;
  logic [CNT_W-1:0] fillNext;

  assign flushNow = flushCfg | flushIntf | (regWr & regWdata[B_FLUSH]);
  assign shortNow = regWr & regWdata[B_SHORT];
  assign wrAccept = wrValid & ~trig[wrSel];
  assign fillNext = fill[wrSel] + CNT_W'(wrAccept);
  assign trigNow  = ~trig[wrSel] &
                    ((wrAccept && fillNext == CNT_W'(PKT_BYTES)) | shortNow);
  assign tokGo    = inToken & ~busy;
  assign doneGo   = txDone & busy;
  assign byteGo   = byteReq & busy;
  assign hasByte  = rdPtr < fill[rdSel];
  assign urSet    = (tokGo & ~trig[rdSel] & ~pktDone) | (byteGo & ~hasByte);

  assign strb.wrEn  = wrAccept & ~flushNow;
  assign strb.wrBuf = wrSel;
  assign strb.rdEn  = byteGo & hasByte;
  assign strb.rdBuf = rdSel;
  assign wrAddr     = fill[wrSel][AW-1:0];
  assign rdAddr     = rdPtr[AW-1:0];
  assign svc        = ~(trig[0] & trig[1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fill[0]   <= '0;
      fill[1]   <= '0;
      trig      <= '0;
      wrSel     <= 1'b0;
      rdSel     <= 1'b0;
      busy      <= 1'b0;
      rdPtr     <= '0;
      sendOut   <= 1'b0;
      nakOut    <= 1'b0;
      sendLen   <= '0;
      byteValid <= 1'b0;
      pktDone   <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      sendOut   <= 1'b0;
      nakOut    <= 1'b0;
      byteValid <= byteGo;

      // loading side
      if (wrAccept) fill[wrSel] <= fillNext;
      if (trigNow) begin
        trig[wrSel] <= 1'b1;
        wrSel       <= ~wrSel;
      end

      // token decision
      if (tokGo) begin
        if (trig[rdSel]) begin
          sendOut <= 1'b1;
          sendLen <= fill[rdSel];
          busy    <= 1'b1;
          rdPtr   <= '0;
        end else if (pktDone) begin
          nakOut  <= 1'b1;
        end else begin
          sendOut <= 1'b1;
          sendLen <= '0;
        end
      end

      if (byteGo && hasByte) rdPtr <= rdPtr + 1'b1;

      // release of the sent buffer
      if (doneGo) begin
        trig[rdSel] <= 1'b0;
        fill[rdSel] <= '0;
        rdSel       <= ~rdSel;
        busy        <= 1'b0;
      end

      pktDone  <= doneGo | (pktDone & ~(regWr & regWdata[B_DONE]));
      underrun <= urSet  | (underrun & ~(regWr & regWdata[B_UR]));

      // flush overrides all buffer state
      if (flushNow) begin
        fill[0] <= '0;
        fill[1] <= '0;
        trig    <= '0;
        wrSel   <= 1'b0;
        rdSel   <= 1'b0;
        busy    <= 1'b0;
        rdPtr   <= '0;
      end
    end
  end
endmodule

// File: rtl/isoInTxBuf.sv
module isoInTxBuf
  import isoTxPkg::*;
#(
  parameter int PKT_BYTES = 256,
  localparam int AW       = $clog2(PKT_BYTES),
  localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [7:0]       wrData,
  input  logic             regWr,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  input  logic             txIntEn,
  output logic             irq,
  input  logic             inToken,
  output logic             sendOut,
  output logic             nakOut,
  output logic [CNT_W-1:0] sendLen,
  input  logic             byteReq,
  output logic             byteValid,
  output logic [7:0]       byteData,
  input  logic             txDone,
  input  logic             flushCfg,
  input  logic             flushIntf
);
  txStrb_t       strb;
  logic [AW-1:0] wrAddr, rdAddr;
  logic          pktDone, underrun, svc;

  isoTxCtrl #(.PKT_BYTES(PKT_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .regWr(regWr),
    .regWdata(regWdata), .inToken(inToken), .byteReq(byteReq),
    .txDone(txDone), .flushCfg(flushCfg), .flushIntf(flushIntf),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr), .sendOut(sendOut),
    .nakOut(nakOut), .sendLen(sendLen), .byteValid(byteValid),
    .pktDone(pktDone), .underrun(underrun), .svc(svc)
  );

  isoTxData #(.DATA_W(8), .PKT_BYTES(PKT_BYTES)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(byteData)
  );

  // bit 2 (flush), bit 4 (reserved), bit 5 (short) and 7:6 read zero
  assign regRdata = {4'b0000, underrun, 1'b0, pktDone, svc};
  assign irq      = (pktDone & txIntEn) | underrun;
endmodule

// File: rtl/isoInTxBuf_chk.sv
module isoInTxBuf_chk #(
  parameter int PKT_BYTES = 256,
  localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [7:0]       regRdata,
  input logic             txIntEn,
  input logic             irq,
  input logic             inToken,
  input logic             sendOut,
  input logic             nakOut,
  input logic [CNT_W-1:0] sendLen,
  input logic             byteReq,
  input logic             byteValid,
  input logic             flushCfg,
  input logic             flushIntf
);
  p_len_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    sendOut |-> sendLen <= CNT_W'(PKT_BYTES));

  p_resp_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(sendOut && nakOut));

  p_resp_after_token_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sendOut || nakOut) |-> $past(inToken));

  p_byte_after_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(byteReq));

  p_ur_irq_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regRdata[3]) |-> irq);

  p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (regRdata[3] || (regRdata[1] && txIntEn)));

  p_nak_needs_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    nakOut |-> $past(regRdata[1]));

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(flushCfg || flushIntf) |-> regRdata[0]);

  p_zero_bits_r10: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[7:4] == 4'b0000 && !regRdata[2]);
endmodule

bind isoInTxBuf isoInTxBuf_chk #(.PKT_BYTES(PKT_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .regRdata(regRdata), .txIntEn(txIntEn),
  .irq(irq), .inToken(inToken), .sendOut(sendOut), .nakOut(nakOut),
  .sendLen(sendLen), .byteReq(byteReq), .byteValid(byteValid),
  .flushCfg(flushCfg), .flushIntf(flushIntf)
);

// File: tb/isoInTxBuf_bench.sv
module isoInTxBuf_bench;
  localparam int MAXP  = 256;
  localparam int CNT_W = $clog2(MAXP + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic wrValid = 0, regWr = 0, txIntEn = 0, inToken = 0, byteReq = 0;
  logic txDone = 0, flushCfg = 0, flushIntf = 0;
  logic [7:0] wrData = '0, regWdata = '0, regRdata, byteData;
  logic irq, sendOut, nakOut, byteValid;
  logic [CNT_W-1:0] sendLen;

  always #10 clk = ~clk;  // 50 MHz

  isoInTxBuf #(.PKT_BYTES(MAXP)) u_isoInTxBuf (.*);

  int nChk = 0, nBad = 0, cyc = 0;
  bit ended = 0;

  // bench model
  int  mFill [2];
  bit  mTrig [2];
  byte mMem  [2][MAXP];
  bit  mWr, mRd, mDone, mUr;

  task automatic cmp(bit ok, string req, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expStatus();
    return {4'b0000, mUr, 1'b0, mDone, ~(mTrig[0] & mTrig[1])};
  endfunction

  task automatic checkStatus(string req);
    logic e;
    cmp(regRdata == expStatus(), req, "status", regRdata, expStatus());
    e = (mDone & txIntEn) | mUr;
    cmp(irq == e, "R5", "irq", irq, e);
  endtask

  task automatic modelFlush();
    mFill = '{0, 0}; mTrig = '{0, 0}; mWr = 0; mRd = 0;
  endtask

  task automatic loadBytes(int n);
    for (int i = 0; i < n; i++) begin
      byte b = byte'($urandom);
      wrValid = 1; wrData = b;
      @(negedge clk);
      if (!mTrig[mWr]) begin  // R11: otherwise ignored
        mMem[mWr][mFill[mWr]] = b;
        mFill[mWr]++;
        if (mFill[mWr] == MAXP) begin mTrig[mWr] = 1; mWr = ~mWr; end
      end
    end
    wrValid = 0;
  endtask

  task automatic regWrite(logic [7:0] v);
    regWr = 1; regWdata = v;
    @(negedge clk);
    regWr = 0; regWdata = '0;
    if (v[5] && !mTrig[mWr]) begin mTrig[mWr] = 1; mWr = ~mWr; end
    if (v[1]) mDone = 0;
    if (v[3]) mUr = 0;
    if (v[2]) modelFlush();
  endtask

  task automatic busFlush(bit useCfg);
    if (useCfg) flushCfg = 1; else flushIntf = 1;
    @(negedge clk);
    flushCfg = 0; flushIntf = 0;
    modelFlush();
  endtask

  // token, pulls with extra pulls past the end, then done
  task automatic txPacket(string req, int extra);
    inToken = 1;
    @(negedge clk);
    inToken = 0;
    if (mTrig[mRd]) begin
      cmp(sendOut && !nakOut, req, "send", sendOut, 1);
      cmp(int'(sendLen) == mFill[mRd], "R3", "sendLen", sendLen, mFill[mRd]);
      for (int i = 0; i < mFill[mRd] + extra; i++) begin
        int e = (i < mFill[mRd]) ? int'(byte'(mMem[mRd][i])) & 8'hFF : 0;
        byteReq = 1;
        @(negedge clk);
        byteReq = 0;
        if (i >= mFill[mRd]) mUr = 1;
        cmp(byteValid && byteData == 8'(e), (i < mFill[mRd]) ? "R12" : "R8",
            "byteData", byteData, e);
      end
      txDone = 1;
      @(negedge clk);
      txDone = 0;
      mTrig[mRd] = 0; mFill[mRd] = 0; mRd = ~mRd; mDone = 1;
      checkStatus("R4");
    end else if (mDone) begin
      cmp(nakOut && !sendOut, "R7", "nak", nakOut, 1);
    end else begin
      mUr = 1;
      cmp(sendOut && !nakOut && sendLen == 0, "R8", "zero-length", sendLen, 0);
      checkStatus("R8");
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      ended = 1;
      nChk++; nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7315));
    modelFlush(); mDone = 0; mUr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    cmp(regRdata == 8'h01, "R2", "reset status", regRdata, 8'h01);
    cmp(!irq && !sendOut && !nakOut, "R5", "reset outputs", irq, 0);

    // empty endpoint, no completion yet: zero-length and underrun
    txPacket("R8", 0);
    regWrite(8'h08); checkStatus("R8");

    // two full packets, extra writes ignored
    loadBytes(MAXP); checkStatus("R2");
    loadBytes(MAXP); checkStatus("R2");
    loadBytes(5);    checkStatus("R11");
    txPacket("R1", 0);
    txIntEn = 0; @(negedge clk); checkStatus("R5");
    txIntEn = 1; @(negedge clk); checkStatus("R5");
    txPacket("R6", 2);              // sends while completion flag set
    txPacket("R7", 0);              // nothing left: NAK
    regWrite(8'h02); checkStatus("R4");
    regWrite(8'h08); checkStatus("R8");

    // short packets, including an empty one
    loadBytes(5); regWrite(8'h20); checkStatus("R1");
    regWrite(8'h20); checkStatus("R2");
    txPacket("R1", 0);
    txPacket("R1", 0);

    // flushes leave flags alone
    loadBytes(9); regWrite(8'h20); loadBytes(MAXP);
    checkStatus("R2");
    regWrite(8'h04); checkStatus("R9");
    txPacket("R9", 0);
    loadBytes(3); regWrite(8'h20); busFlush(1); checkStatus("R9");
    loadBytes(3); regWrite(8'h20); busFlush(0); checkStatus("R9");
    regWrite(8'hD0); checkStatus("R10");
    regWrite(8'h0A); checkStatus("R4");

    // constrained random mix
    for (int it = 0; it < 40; it++) begin
      int op = $urandom_range(0, 9);
      txIntEn = 1'($urandom);
      case (op)
        0, 1, 2: loadBytes($urandom_range(1, 300));
        3:       regWrite(8'h20);
        4, 5, 6: txPacket("R3", $urandom_range(0, 1));
        7:       regWrite(8'h0A);
        8:       busFlush(1'($urandom));
        default: regWrite(8'h04);
      endcase
      checkStatus("R2");
    end

    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule